// File: doc/BRIEF.md
# Slave Delay-Line Phase Code Generator

This block sits in one byte lane of a DDR memory interface. A master delay-locked loop measures the clock period as a tap count; from that single measurement the block derives three delay codes, one for each slave delay line of the lane: the write data line, the write strobe line and the read strobe line. Each code is the measured period scaled by a per-channel fraction, and then trimmed by a signed per-channel tap offset. By default both strobe codes sit at a quarter period, which centres the read strobe in an edge-aligned read data eye. The write data code sits a quarter period after the write strobe code, so write data leaves centre-aligned with its strobe.

Leveling logic loads the fraction and offset of each channel through a small register write port. These writes go into shadow registers. Nothing reaches the delay lines until an update-allow input is raised. On that cycle the block recomputes all three codes from the shadow values and the latest locked master measurement, and the codes change together on the next clock edge. While the master reports no lock, its code is ignored and the last locked value is used. A readback port returns the code that is currently applied on a channel.

Top module: `slave_phase_gen`

## Requirements
- R1: While synchronous active-low reset is applied, all three output codes are zero. After reset the shadow fractions are 128/256 for write data (address 0), 64/256 for write strobe (address 1) and 64/256 for read strobe (address 2), and all offsets are zero.
- R2: An applied code equals floor(master × fraction / 256) + offset, where the fraction is an unsigned 8-bit value in 256ths of the period.
- R3: With the default fractions, both strobe codes are a quarter of the master code and the write data code is half of it. The write data and write strobe codes therefore differ by a quarter period.
- R4: The output codes change only on the clock edge that samples update-allow high, and all three change on that same edge. In every other cycle they hold.
- R5: A configuration write changes only the shadow value of its channel. It has no effect on the outputs until the next update.
- R6: A master code is ignored while master lock is low. An update then uses the last code that was sampled with lock high. Before any lock has been seen, an update leaves the outputs at zero.
- R7: The result saturates to 0 when it is negative and to 2^CODE_W−1 when it is above the code range.
- R8: Readback address 0 returns the write data code, 1 the write strobe code, 2 the read strobe code, and 3 returns zero. A write to address 3 is ignored.
- R9: The offset is an OFF_W-bit two's-complement value, so with the default width it runs from −32 to +31 taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mst_code | input | CODE_W | Full-period tap count from the master loop |
| mst_lock | input | 1 | Master measurement is valid |
| upd_allow | input | 1 | Safe window for applying new codes |
| cfg_we | input | 1 | Write strobe for the shadow registers |
| cfg_addr | input | 2 | Channel selected by a write |
| cfg_ratio | input | RATIO_W | Fraction to write, in 256ths |
| cfg_offset | input | OFF_W | Signed tap offset to write |
| cfg_raddr | input | 2 | Channel selected for readback |
| cfg_rdata | output | CODE_W | Applied code of the selected channel |
| wdq_code | output | CODE_W | Write data delay code |
| wdqs_code | output | CODE_W | Write strobe delay code |
| rdqs_code | output | CODE_W | Read strobe delay code |

## Verification
The bench builds the block with its default parameters: a 9-bit code, an 8-bit fraction and a 6-bit offset. With these widths a full-scale master code, a near-unity fraction and the largest positive offset reach the top clamp in one update. A small master code with the most negative offset reaches the bottom clamp. The test also covers updates made while lock is low and before any lock, so both the held-measurement path and the never-locked path are exercised.

// File: rtl/spg_pkg.sv
// Package: channel numbering shared by the phase code generator and its bench.
// Assumes three slave channels per byte lane; address 3 is unused.
package spg_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        CH_WDQ  = 2'd0,
        CH_WDQS = 2'd1,
        CH_RDQS = 2'd2,
        CH_NONE = 2'd3
    } spg_ch_e;

    // Reset fraction of a channel: write data at half period, strobes at quarter.
    function automatic int default_ratio(input int ch, input int ratio_w);
        int quarter;
        quarter = 1 << (ratio_w - 2);
        return (ch == int'(CH_WDQ)) ? 2 * quarter : quarter;
    endfunction
endpackage

// File: rtl/spg_shadow.sv
// Module: holds the leveling-loaded fraction and offset of one channel.
// Assumes writes may arrive at any time; the values are consumed only at update.
module spg_shadow #(
    parameter int RATIO_W   = 8,
    parameter int OFF_W     = 6,
    parameter int DEF_RATIO = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [OFF_W-1:0]   off_o
);
    logic [RATIO_W-1:0] ratio_q;
    logic [OFF_W-1:0]   off_q;

    // Capture a new fraction and offset on a write addressed to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(DEF_RATIO);
            off_q   <= '0;
        end else if (we_i) begin
            ratio_q <= ratio_i;
            off_q   <= off_i;
        end
    end

    assign ratio_o = ratio_q;
    assign off_o   = off_q;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable({ratio_q, off_q})); // R5
endmodule

// File: rtl/spg_scale.sv
// Module: scales a period tap count by a fraction and adds a signed offset.
// Assumes OFF_W <= CODE_W; the result is clamped to the code range.
module spg_scale #(
    parameter int CODE_W  = 9,
    parameter int RATIO_W = 8,
    parameter int OFF_W   = 6
) (
    input  logic [CODE_W-1:0]  mst_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [CODE_W-1:0]  code_o
);
    localparam int PROD_W = CODE_W + RATIO_W;
    localparam int SUM_W  = CODE_W + 2;

    logic [PROD_W-1:0] prod;
    logic [CODE_W-1:0] scaled;
    logic [SUM_W-1:0]  sum;

    // Multiply, drop the fraction bits, add the sign-extended offset, then clamp.
    always_comb begin
        prod   = {{RATIO_W{1'b0}}, mst_i} * {{CODE_W{1'b0}}, ratio_i};
        scaled = prod[PROD_W-1:RATIO_W];
        sum    = {2'b00, scaled} + {{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i};
        if (sum[SUM_W-1])
            code_o = '0;
        else if (sum[SUM_W-2:CODE_W] != '0)
            code_o = '1;
        else
            code_o = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/slave_phase_gen.sv
// Module: derives three slave delay codes for one byte lane from a master
// period measurement, applying them together only while updates are allowed.
// Assumes upd_allow is asserted by the controller in an idle bus window.
module slave_phase_gen
    import spg_pkg::*;
#(
    parameter int CODE_W  = 9,
    parameter int RATIO_W = 8,
    parameter int OFF_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  mst_code,
    input  logic               mst_lock,
    input  logic               upd_allow,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [OFF_W-1:0]   cfg_offset,
    input  logic [1:0]         cfg_raddr,
    output logic [CODE_W-1:0]  cfg_rdata,
    output logic [CODE_W-1:0]  wdq_code,
    output logic [CODE_W-1:0]  wdqs_code,
    output logic [CODE_W-1:0]  rdqs_code
);
    logic [CODE_W-1:0] held_q;
    logic              held_vld_q;
    logic [CODE_W-1:0] src_code;
    logic              src_ok;
    logic [CODE_W-1:0] code_q [NCH];

    // Keep the last master code that was reported with lock high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= '0;
            held_vld_q <= 1'b0;
        end else if (mst_lock) begin
            held_q     <= mst_code;
            held_vld_q <= 1'b1;
        end
    end

    // Use the live code when locked, otherwise the held one.
    always_comb begin
        src_code = mst_lock ? mst_code : held_q;
        src_ok   = mst_lock | held_vld_q;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [RATIO_W-1:0] ratio;
        logic [OFF_W-1:0]   off;
        logic [CODE_W-1:0]  next_code;
        logic               sel;

        assign sel = cfg_we && (cfg_addr == 2'(ch));

        spg_shadow #(
            .RATIO_W  (RATIO_W),
            .OFF_W    (OFF_W),
            .DEF_RATIO(default_ratio(ch, RATIO_W))
        ) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (sel),
            .ratio_i(cfg_ratio),
            .off_i  (cfg_offset),
            .ratio_o(ratio),
            .off_o  (off)
        );

        spg_scale #(
            .CODE_W (CODE_W),
            .RATIO_W(RATIO_W),
            .OFF_W  (OFF_W)
        ) u_scale (
            .mst_i  (src_code),
            .ratio_i(ratio),
            .off_i  (off),
            .code_o (next_code)
        );

        // Apply the new code only in an allowed window with a valid measurement.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[ch] <= '0;
            else if (upd_allow && src_ok)
                code_q[ch] <= next_code;
        end
    end

    assign wdq_code  = code_q[CH_WDQ];
    assign wdqs_code = code_q[CH_WDQS];
    assign rdqs_code = code_q[CH_RDQS];

    // Return the applied code of the channel chosen for readback.
    always_comb begin
        case (spg_ch_e'(cfg_raddr))
            CH_WDQ:  cfg_rdata = code_q[CH_WDQ];
            CH_WDQS: cfg_rdata = code_q[CH_WDQS];
            CH_RDQS: cfg_rdata = code_q[CH_RDQS];
            default: cfg_rdata = '0;
        endcase
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_allow |=> $stable({wdq_code, wdqs_code, rdqs_code})); // R4
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_lock |=> $stable(held_q)); // R6
    AST_NEVER_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !held_vld_q |-> ({wdq_code, wdqs_code, rdqs_code} == '0)); // R6
    AST_RB_WDQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == 2'd0) |-> (cfg_rdata == wdq_code)); // R8
endmodule

// File: tb/slave_phase_gen_tb.sv
`timescale 1ns/1ps
module slave_phase_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] mst_code = '0;
    logic       mst_lock = 1'b0;
    logic       upd_allow = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_ratio = '0;
    logic [5:0] cfg_offset = '0;
    logic [1:0] cfg_raddr = '0;
    logic [8:0] cfg_rdata, wdq_code, wdqs_code, rdqs_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         due;
        logic [8:0] wdq;
        logic [8:0] wdqs;
        logic [8:0] rdqs;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int m_ratio [3];
    int m_off [3];
    int m_held = 0;
    bit m_vld = 0;
    int m_out [3];

    slave_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mst_code(mst_code), .mst_lock(mst_lock),
        .upd_allow(upd_allow), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_ratio(cfg_ratio), .cfg_offset(cfg_offset), .cfg_raddr(cfg_raddr),
        .cfg_rdata(cfg_rdata), .wdq_code(wdq_code), .wdqs_code(wdqs_code),
        .rdqs_code(rdqs_code)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_code(int m, int r, int o);
        int v;
        v = ((m * r) >> 8) + o;
        if (v < 0) v = 0;
        if (v > 511) v = 511;
        return v;
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.due = cyc + 1; e.wdq = 9'(m_out[0]); e.wdqs = 9'(m_out[1]);
        e.rdqs = 9'(m_out[2]); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares applied codes against queued expectations.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " wdq"},  int'(wdq_code),  int'(e.wdq));
            chk({e.tag, " wdqs"}, int'(wdqs_code), int'(e.wdqs));
            chk({e.tag, " rdqs"}, int'(rdqs_code), int'(e.rdqs));
        end
    end

    task automatic hold(string tag);
        push(tag);
        @(negedge clk);
    endtask

    task automatic cfg_write(int ch, int r, int o);
        cfg_we = 1'b1; cfg_addr = 2'(ch); cfg_ratio = 8'(r); cfg_offset = 6'(o);
        if (ch < 3) begin m_ratio[ch] = r; m_off[ch] = o; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_master(int code, bit lock);
        mst_code = 9'(code); mst_lock = lock;
        if (lock) begin m_held = code; m_vld = 1; end
        @(negedge clk);
    endtask

    task automatic do_update(string tag);
        upd_allow = 1'b1;
        if (m_vld)
            for (int c = 0; c < 3; c++) m_out[c] = model_code(m_held, m_ratio[c], m_off[c]);
        push(tag);
        @(negedge clk);
        upd_allow = 1'b0;
    endtask

    task automatic rb(int addr, int exp, string tag);
        cfg_raddr = 2'(addr);
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        m_ratio = '{128, 64, 64};
        m_off   = '{0, 0, 0};
        m_out   = '{0, 0, 0};
        repeat (4) @(negedge clk);
        // R1: outputs zero out of reset
        chk("R1 wdq reset", int'(wdq_code), 0);
        chk("R1 rdqs reset", int'(rdqs_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rb(3, 0, "R8 addr3 reads zero");
        // R6: update before any lock leaves zero
        do_update("R6 never locked");
        // R3/R2: default fractions, wdq=200 wdqs=100 rdqs=100
        set_master(400, 1);
        do_update("R3 default quarter/half");
        hold("R4 hold after update");
        hold("R4 hold second cycle");
        // R5: shadow write invisible until update
        cfg_write(2, 96, 0);
        hold("R5 write not applied");
        hold("R5 still not applied");
        do_update("R2 rdqs ratio 96");
        // R6: unlocked master ignored, held 400 used
        set_master(300, 0);
        do_update("R6 unlocked ignored");
        // R6: new lock captured, then dropped
        set_master(200, 1);
        set_master(500, 0);
        do_update("R6 held last locked");
        // R9: negative offset on wdqs
        cfg_write(1, 64, -5);
        do_update("R9 signed offset");
        // R7: top clamp on wdq
        set_master(511, 1);
        cfg_write(0, 255, 31);
        do_update("R7 top saturation");
        // R7: bottom clamp on rdqs
        set_master(20, 1);
        cfg_write(2, 64, -32);
        do_update("R7 bottom saturation");
        // R8: write to address 3 ignored
        cfg_write(3, 1, 1);
        do_update("R8 addr3 write ignored");
        hold("R4 final hold");
        repeat (3) @(negedge clk);
        rb(0, m_out[0], "R8 readback wdq");
        rb(1, m_out[1], "R8 readback wdqs");
        rb(2, m_out[2], "R8 readback rdqs");
        rb(3, 0, "R8 readback none");
        chk("R4 scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule